// File: doc/BRIEF.md
# Multithreaded Fetch PC Sequencer

The sequencer holds one program counter, one sequence counter and one PC-valid flag for each hardware thread of a fine-grained multithreaded core. Each cycle the fetch stage may ask for the next address of one thread. A thread with a valid PC and no competing event is granted. The grant returns the thread's current PC and sequence number, and the PC then steps by the instruction size.

A resolving pipeline stage reports control-flow outcomes on the branch-update port. A predicted-taken control instruction loads its target and emits a squash request carrying its sequence number and stage. A return with no prediction parks the thread: fetch is refused and a block pulse is raised toward the earlier stages. Redirects from the squash network come in on several lanes at once. For each thread the oldest redirect wins. Winning a redirect reloads the PC and revalidates the thread, and it releases the stage that parked the thread. Threads are started and stopped through activate and deactivate controls.

Top module: `fetch_pc_sequencer`

## Requirements
- R1: A fetch request for a thread whose PC-valid flag is clear gives `fetch_stall_o`=1 and `fetch_gnt_o`=0, and leaves that thread's PC and sequence counter unchanged.
- R2: A granted fetch returns the thread's PC on `fetch_addr_o` and its sequence counter on `fetch_seq_o` in the same cycle. The PC then advances by 4 and the counter by 1. Each thread has its own PC and counter.
- R3: A branch update with control=1, return=1 and predicted-taken=0 clears the thread's PC-valid flag and records the update's stage. One cycle later it pulses `block_o` bit (stage*NUM_THR + thread).
- R4: A branch update with control=1 and predicted-taken=1 loads the target into the thread's PC. One cycle later it pulses `sqo_valid_o` with that update's sequence number, thread and stage.
- R5: A branch update with control=0, or with control=1, return=0 and predicted-taken=0, changes no PC and raises no squash output.
- R6: When several squash lanes name the same thread in one cycle, only the lane with the smallest sequence number (unsigned) is applied. On equal numbers the lowest lane index wins. Lanes that name different threads are all applied.
- R7: An applied squash loads the PC with the lane target when the lane's control flag is 1, or with the lane PC plus 4 otherwise. It also sets PC-valid.
- R8: An applied squash on a thread whose PC-valid flag was clear pulses `unblock_o` bit (recorded stage*NUM_THR + thread) one cycle later. A thread that was valid gives no unblock pulse.
- R9: Activating a thread loads its PC from `act_pc_i` and sets PC-valid.
- R10: Deactivating a thread clears PC-valid and resets its recorded blocking stage to 0.
- R11: A fetch for a thread that has a squash, an activate, a deactivate or a redirecting or parking branch update in the same cycle is stalled, and its counter does not move.
- R12: After reset every thread is invalid, every sequence counter is 0, and `block_o`, `unblock_o` and `sqo_valid_o` are 0.
- R13: For one thread in one cycle, deactivate overrides activate, activate overrides a squash, and a squash overrides a branch update. The squash output of R4 is raised regardless.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Fetch request |
| fetch_tid_i | input | TID_W | Thread of the fetch request |
| fetch_gnt_o | output | 1 | Fetch granted |
| fetch_stall_o | output | 1 | Fetch refused |
| fetch_addr_o | output | PC_W | Fetch address on grant |
| fetch_seq_o | output | SEQ_W | Sequence number on grant |
| bu_valid_i | input | 1 | Branch update present |
| bu_tid_i | input | TID_W | Branch update thread |
| bu_stage_i | input | STG_W | Stage raising the update |
| bu_seq_i | input | SEQ_W | Sequence number of the instruction |
| bu_is_ctrl_i | input | 1 | Instruction is a control transfer |
| bu_is_ret_i | input | 1 | Instruction is a return |
| bu_pred_taken_i | input | 1 | Predicted taken |
| bu_target_i | input | PC_W | Predicted target |
| sq_valid_i | input | NUM_SQ | Squash lane valid flags |
| sq_tid_i | input | NUM_SQ*TID_W | Squash lane threads |
| sq_seq_i | input | NUM_SQ*SEQ_W | Squash lane sequence numbers |
| sq_is_ctrl_i | input | NUM_SQ | Lane instruction is a control transfer |
| sq_target_i | input | NUM_SQ*PC_W | Lane predicted targets |
| sq_pc_i | input | NUM_SQ*PC_W | Lane instruction PCs |
| act_valid_i | input | 1 | Activate a thread |
| act_tid_i | input | TID_W | Thread to activate |
| act_pc_i | input | PC_W | Architectural PC for activation |
| deact_valid_i | input | 1 | Deactivate a thread |
| deact_tid_i | input | TID_W | Thread to deactivate |
| block_o | output | NUM_STG*NUM_THR | Block pulses, bit stage*NUM_THR+thread |
| unblock_o | output | NUM_STG*NUM_THR | Unblock pulses, same indexing |
| sqo_valid_o | output | 1 | Squash request out |
| sqo_tid_o | output | TID_W | Squash request thread |
| sqo_seq_o | output | SEQ_W | Squash after this sequence number |
| sqo_stage_o | output | STG_W | Stage issuing the squash |

## Verification
The bench sweeps interleaved fetches over all threads. A counter or PC shared between threads, or a step other than 4, shows up as a wrong address or number. It drives competing lanes with out-of-order and equal sequence numbers. A design that picked the youngest lane, or the highest index on a tie, would load the wrong PC. It parks a thread, deactivates it and then redirects it. A design that kept the stale stage would pulse the wrong unblock bit, and one that unblocked valid threads would pulse spuriously. Fetches that collide with redirects, and activate, squash and branch events that collide on one thread, expose a wrong priority as a wrong address or an advanced counter.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_DEACT,
    OP_ACT,
    OP_SQUASH,
    OP_REDIR,
    OP_PARK,
    OP_ADV
  } thr_op_e;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fpc_squash_arb.sv
module fpc_squash_arb #(
  parameter int NUM_THR    = 4,
  parameter int NUM_SQ     = 2,
  parameter int PC_W       = 32,
  parameter int SEQ_W      = 16,
  parameter int INST_BYTES = 4,
  localparam int TID_W     = fpc_pkg::idx_w(NUM_THR),
  localparam int LANE_W    = fpc_pkg::idx_w(NUM_SQ)
) (
  input  logic             lane_vld_i  [NUM_SQ],
  input  logic [TID_W-1:0] lane_tid_i  [NUM_SQ],
  input  logic [SEQ_W-1:0] lane_seq_i  [NUM_SQ],
  input  logic             lane_ctrl_i [NUM_SQ],
  input  logic [PC_W-1:0]  lane_tgt_i  [NUM_SQ],
  input  logic [PC_W-1:0]  lane_pc_i   [NUM_SQ],
  output logic             take_o      [NUM_THR],
  output logic [PC_W-1:0]  npc_o       [NUM_THR]
);
  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    logic [LANE_W-1:0] best;
    logic [SEQ_W-1:0]  best_seq;
    logic              hit;

    always_comb begin
      hit      = 1'b0;
      best     = '0;
      best_seq = '1;
      for (int l = 0; l < NUM_SQ; l++) begin
        // strict compare keeps the lower lane on equal numbers
        if (lane_vld_i[l] && lane_tid_i[l] == TID_W'(t) &&
            (!hit || lane_seq_i[l] < best_seq)) begin
          hit      = 1'b1;
          best     = LANE_W'(l);
          best_seq = lane_seq_i[l];
        end
      end
    end

    assign take_o[t] = hit;
    assign npc_o[t]  = lane_ctrl_i[best] ? lane_tgt_i[best]
                                         : lane_pc_i[best] + PC_W'(INST_BYTES);
  end
endmodule

// File: rtl/fpc_thread_ctx.sv
module fpc_thread_ctx
  import fpc_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int SEQ_W      = 16,
  parameter int STG_W      = 3,
  parameter int INST_BYTES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             deact_i,
  input  logic             act_i,
  input  logic [PC_W-1:0]  act_pc_i,
  input  logic             sq_take_i,
  input  logic [PC_W-1:0]  sq_pc_i,
  input  logic             bu_redir_i,
  input  logic [PC_W-1:0]  bu_tgt_i,
  input  logic             bu_park_i,
  input  logic [STG_W-1:0] bu_stage_i,
  input  logic             fetch_adv_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic             valid_o,
  output logic             busy_o,
  output logic             park_o,
  output logic             unblock_o,
  output logic [STG_W-1:0] blk_stage_o
);
  logic [PC_W-1:0]  pc_q;
  logic [SEQ_W-1:0] seq_q;
  logic             valid_q;
  logic [STG_W-1:0] stage_q;
  thr_op_e          op;

  always_comb begin
    if (deact_i)          op = OP_DEACT;
    else if (act_i)       op = OP_ACT;
    else if (sq_take_i)   op = OP_SQUASH;
    else if (bu_redir_i)  op = OP_REDIR;
    else if (bu_park_i)   op = OP_PARK;
    else if (fetch_adv_i) op = OP_ADV;
    else                  op = OP_IDLE;
  end

  assign busy_o    = deact_i | act_i | sq_take_i | bu_redir_i | bu_park_i;
  assign park_o    = (op == OP_PARK);
  assign unblock_o = (op == OP_SQUASH) && !valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      seq_q   <= '0;
      valid_q <= 1'b0;
      stage_q <= '0;
    end else begin
      unique case (op)
        OP_DEACT: begin
          valid_q <= 1'b0;
          stage_q <= '0;
        end
        OP_ACT: begin
          pc_q    <= act_pc_i;
          valid_q <= 1'b1;
        end
        OP_SQUASH: begin
          pc_q    <= sq_pc_i;
          valid_q <= 1'b1;
        end
        OP_REDIR: pc_q <= bu_tgt_i;
        OP_PARK: begin
          valid_q <= 1'b0;
          stage_q <= bu_stage_i;
        end
        OP_ADV: begin
          pc_q  <= pc_q + PC_W'(INST_BYTES);
          seq_q <= seq_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign pc_o        = pc_q;
  assign seq_o       = seq_q;
  assign valid_o     = valid_q;
  assign blk_stage_o = stage_q;
endmodule

// File: rtl/fetch_pc_sequencer.sv
module fetch_pc_sequencer #(
  parameter int NUM_THR    = 4,
  parameter int NUM_STG    = 5,
  parameter int NUM_SQ     = 2,
  parameter int PC_W       = 32,
  parameter int SEQ_W      = 16,
  parameter int INST_BYTES = 4,
  localparam int TID_W     = fpc_pkg::idx_w(NUM_THR),
  localparam int STG_W     = fpc_pkg::idx_w(NUM_STG),
  localparam int PULSE_W   = NUM_STG * NUM_THR
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fetch_req_i,
  input  logic [TID_W-1:0]        fetch_tid_i,
  output logic                    fetch_gnt_o,
  output logic                    fetch_stall_o,
  output logic [PC_W-1:0]         fetch_addr_o,
  output logic [SEQ_W-1:0]        fetch_seq_o,
  input  logic                    bu_valid_i,
  input  logic [TID_W-1:0]        bu_tid_i,
  input  logic [STG_W-1:0]        bu_stage_i,
  input  logic [SEQ_W-1:0]        bu_seq_i,
  input  logic                    bu_is_ctrl_i,
  input  logic                    bu_is_ret_i,
  input  logic                    bu_pred_taken_i,
  input  logic [PC_W-1:0]         bu_target_i,
  input  logic [NUM_SQ-1:0]       sq_valid_i,
  input  logic [NUM_SQ*TID_W-1:0] sq_tid_i,
  input  logic [NUM_SQ*SEQ_W-1:0] sq_seq_i,
  input  logic [NUM_SQ-1:0]       sq_is_ctrl_i,
  input  logic [NUM_SQ*PC_W-1:0]  sq_target_i,
  input  logic [NUM_SQ*PC_W-1:0]  sq_pc_i,
  input  logic                    act_valid_i,
  input  logic [TID_W-1:0]        act_tid_i,
  input  logic [PC_W-1:0]         act_pc_i,
  input  logic                    deact_valid_i,
  input  logic [TID_W-1:0]        deact_tid_i,
  output logic [PULSE_W-1:0]      block_o,
  output logic [PULSE_W-1:0]      unblock_o,
  output logic                    sqo_valid_o,
  output logic [TID_W-1:0]        sqo_tid_o,
  output logic [SEQ_W-1:0]        sqo_seq_o,
  output logic [STG_W-1:0]        sqo_stage_o
);
  logic             lane_vld  [NUM_SQ];
  logic [TID_W-1:0] lane_tid  [NUM_SQ];
  logic [SEQ_W-1:0] lane_seq  [NUM_SQ];
  logic             lane_ctrl [NUM_SQ];
  logic [PC_W-1:0]  lane_tgt  [NUM_SQ];
  logic [PC_W-1:0]  lane_pc   [NUM_SQ];

  for (genvar l = 0; l < NUM_SQ; l++) begin : g_lane
    assign lane_vld[l]  = sq_valid_i[l];
    assign lane_tid[l]  = sq_tid_i[l*TID_W +: TID_W];
    assign lane_seq[l]  = sq_seq_i[l*SEQ_W +: SEQ_W];
    assign lane_ctrl[l] = sq_is_ctrl_i[l];
    assign lane_tgt[l]  = sq_target_i[l*PC_W +: PC_W];
    assign lane_pc[l]   = sq_pc_i[l*PC_W +: PC_W];
  end

  logic            sq_take [NUM_THR];
  logic [PC_W-1:0] sq_npc  [NUM_THR];

  fpc_squash_arb #(
    .NUM_THR(NUM_THR), .NUM_SQ(NUM_SQ), .PC_W(PC_W),
    .SEQ_W(SEQ_W), .INST_BYTES(INST_BYTES)
  ) u_arb (
    .lane_vld_i (lane_vld),
    .lane_tid_i (lane_tid),
    .lane_seq_i (lane_seq),
    .lane_ctrl_i(lane_ctrl),
    .lane_tgt_i (lane_tgt),
    .lane_pc_i  (lane_pc),
    .take_o     (sq_take),
    .npc_o      (sq_npc)
  );

  logic bu_ctrl, bu_redir, bu_park;
  assign bu_ctrl  = bu_valid_i & bu_is_ctrl_i;
  assign bu_redir = bu_ctrl & bu_pred_taken_i;
  assign bu_park  = bu_ctrl & bu_is_ret_i & ~bu_pred_taken_i;

  logic [PC_W-1:0]  thr_pc    [NUM_THR];
  logic [SEQ_W-1:0] thr_seq   [NUM_THR];
  logic [STG_W-1:0] thr_stage [NUM_THR];
  logic [NUM_THR-1:0] thr_valid, thr_busy, thr_park, thr_unblk;
  logic tid_ok;

  assign tid_ok        = 32'(fetch_tid_i) < NUM_THR;
  assign fetch_gnt_o   = fetch_req_i && tid_ok &&
                         thr_valid[fetch_tid_i] && !thr_busy[fetch_tid_i];
  assign fetch_stall_o = fetch_req_i && !fetch_gnt_o;
  assign fetch_addr_o  = thr_pc[fetch_tid_i];
  assign fetch_seq_o   = thr_seq[fetch_tid_i];

  for (genvar t = 0; t < NUM_THR; t++) begin : g_ctx
    logic hit_bu;
    assign hit_bu = (bu_tid_i == TID_W'(t));

    fpc_thread_ctx #(
      .PC_W(PC_W), .SEQ_W(SEQ_W), .STG_W(STG_W), .INST_BYTES(INST_BYTES)
    ) u_ctx (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .deact_i    (deact_valid_i && deact_tid_i == TID_W'(t)),
      .act_i      (act_valid_i && act_tid_i == TID_W'(t)),
      .act_pc_i   (act_pc_i),
      .sq_take_i  (sq_take[t]),
      .sq_pc_i    (sq_npc[t]),
      .bu_redir_i (bu_redir && hit_bu),
      .bu_tgt_i   (bu_target_i),
      .bu_park_i  (bu_park && hit_bu),
      .bu_stage_i (bu_stage_i),
      .fetch_adv_i(fetch_gnt_o && fetch_tid_i == TID_W'(t)),
      .pc_o       (thr_pc[t]),
      .seq_o      (thr_seq[t]),
      .valid_o    (thr_valid[t]),
      .busy_o     (thr_busy[t]),
      .park_o     (thr_park[t]),
      .unblock_o  (thr_unblk[t]),
      .blk_stage_o(thr_stage[t])
    );
  end

  logic [PULSE_W-1:0] blk_nxt, unb_nxt;

  always_comb begin
    blk_nxt = '0;
    unb_nxt = '0;
    for (int t = 0; t < NUM_THR; t++) begin
      if (thr_park[t] && 32'(bu_stage_i) < NUM_STG)
        blk_nxt[32'(bu_stage_i)*NUM_THR + t] = 1'b1;
      if (thr_unblk[t] && 32'(thr_stage[t]) < NUM_STG)
        unb_nxt[32'(thr_stage[t])*NUM_THR + t] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      block_o     <= '0;
      unblock_o   <= '0;
      sqo_valid_o <= 1'b0;
      sqo_tid_o   <= '0;
      sqo_seq_o   <= '0;
      sqo_stage_o <= '0;
    end else begin
      block_o     <= blk_nxt;
      unblock_o   <= unb_nxt;
      sqo_valid_o <= bu_redir;
      if (bu_redir) begin
        sqo_tid_o   <= bu_tid_i;
        sqo_seq_o   <= bu_seq_i;
        sqo_stage_o <= bu_stage_i;
      end
    end
  end
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
  parameter int NUM_THR    = 4,
  parameter int NUM_STG    = 5,
  parameter int NUM_SQ     = 2,
  parameter int PC_W       = 32,
  parameter int SEQ_W      = 16,
  parameter int INST_BYTES = 4,
  localparam int TID_W     = fpc_pkg::idx_w(NUM_THR),
  localparam int PULSE_W   = NUM_STG * NUM_THR
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               fetch_req_i,
  input logic [TID_W-1:0]   fetch_tid_i,
  input logic               fetch_gnt_o,
  input logic               fetch_stall_o,
  input logic [PC_W-1:0]    fetch_addr_o,
  input logic [SEQ_W-1:0]   fetch_seq_o,
  input logic               bu_valid_i,
  input logic [TID_W-1:0]   bu_tid_i,
  input logic [SEQ_W-1:0]   bu_seq_i,
  input logic               bu_is_ctrl_i,
  input logic               bu_is_ret_i,
  input logic               bu_pred_taken_i,
  input logic [NUM_SQ-1:0]  sq_valid_i,
  input logic               act_valid_i,
  input logic               deact_valid_i,
  input logic [PULSE_W-1:0] block_o,
  input logic [PULSE_W-1:0] unblock_o,
  input logic               sqo_valid_o,
  input logic [TID_W-1:0]   sqo_tid_o,
  input logic [SEQ_W-1:0]   sqo_seq_o
);
  logic ev_any, redir, park;
  assign ev_any = (|sq_valid_i) | bu_valid_i | act_valid_i | deact_valid_i;
  assign redir  = bu_valid_i && bu_is_ctrl_i && bu_pred_taken_i;
  assign park   = bu_valid_i && bu_is_ctrl_i && bu_is_ret_i && !bu_pred_taken_i;

  p_stall_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_stall_o |-> (fetch_req_i && !fetch_gnt_o));

  p_seq_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_gnt_o && $past(fetch_gnt_o) && fetch_tid_i == $past(fetch_tid_i) &&
     !$past(ev_any))
    |-> (fetch_addr_o == $past(fetch_addr_o) + PC_W'(INST_BYTES) &&
         fetch_seq_o == $past(fetch_seq_o) + SEQ_W'(1)));

  p_block_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(block_o));

  p_block_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|block_o) |-> $past(park));

  p_redir_out_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir |=> (sqo_valid_o && sqo_seq_o == $past(bu_seq_i) &&
               sqo_tid_o == $past(bu_tid_i)));

  p_no_redir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redir |=> !sqo_valid_o);

  p_unblock_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(unblock_o) <= NUM_SQ);
endmodule

bind fetch_pc_sequencer fpc_checker #(
  .NUM_THR(NUM_THR), .NUM_STG(NUM_STG), .NUM_SQ(NUM_SQ),
  .PC_W(PC_W), .SEQ_W(SEQ_W), .INST_BYTES(INST_BYTES)
) u_fpc_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .fetch_req_i    (fetch_req_i),
  .fetch_tid_i    (fetch_tid_i),
  .fetch_gnt_o    (fetch_gnt_o),
  .fetch_stall_o  (fetch_stall_o),
  .fetch_addr_o   (fetch_addr_o),
  .fetch_seq_o    (fetch_seq_o),
  .bu_valid_i     (bu_valid_i),
  .bu_tid_i       (bu_tid_i),
  .bu_seq_i       (bu_seq_i),
  .bu_is_ctrl_i   (bu_is_ctrl_i),
  .bu_is_ret_i    (bu_is_ret_i),
  .bu_pred_taken_i(bu_pred_taken_i),
  .sq_valid_i     (sq_valid_i),
  .act_valid_i    (act_valid_i),
  .deact_valid_i  (deact_valid_i),
  .block_o        (block_o),
  .unblock_o      (unblock_o),
  .sqo_valid_o    (sqo_valid_o),
  .sqo_tid_o      (sqo_tid_o),
  .sqo_seq_o      (sqo_seq_o)
);

// File: tb/fetch_pc_sequencer_bench.sv
`timescale 1ns/1ps
module fetch_pc_sequencer_bench;
  localparam int NT = 4, NS = 5, NQ = 2, PW = 32, SW = 16;
  localparam int TW = 2, GW = 3, PLW = NS * NT;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic fetch_req_i, fetch_gnt_o, fetch_stall_o;
  logic [TW-1:0] fetch_tid_i;
  logic [PW-1:0] fetch_addr_o;
  logic [SW-1:0] fetch_seq_o;
  logic bu_valid_i, bu_is_ctrl_i, bu_is_ret_i, bu_pred_taken_i;
  logic [TW-1:0] bu_tid_i;
  logic [GW-1:0] bu_stage_i;
  logic [SW-1:0] bu_seq_i;
  logic [PW-1:0] bu_target_i;
  logic [NQ-1:0] sq_valid_i, sq_is_ctrl_i;
  logic [NQ*TW-1:0] sq_tid_i;
  logic [NQ*SW-1:0] sq_seq_i;
  logic [NQ*PW-1:0] sq_target_i, sq_pc_i;
  logic act_valid_i, deact_valid_i;
  logic [TW-1:0] act_tid_i, deact_tid_i;
  logic [PW-1:0] act_pc_i;
  logic [PLW-1:0] block_o, unblock_o;
  logic sqo_valid_o;
  logic [TW-1:0] sqo_tid_o;
  logic [SW-1:0] sqo_seq_o;
  logic [GW-1:0] sqo_stage_o;

  fetch_pc_sequencer u_fetch_pc_sequencer (.*);

  int checks = 0, fails = 0;
  logic [PW-1:0] m_pc [NT];
  logic [SW-1:0] m_seq [NT];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    fetch_req_i = 0; fetch_tid_i = 0;
    bu_valid_i = 0; bu_tid_i = 0; bu_stage_i = 0; bu_seq_i = 0;
    bu_is_ctrl_i = 0; bu_is_ret_i = 0; bu_pred_taken_i = 0; bu_target_i = 0;
    sq_valid_i = 0; sq_is_ctrl_i = 0; sq_tid_i = 0; sq_seq_i = 0;
    sq_target_i = 0; sq_pc_i = 0;
    act_valid_i = 0; act_tid_i = 0; act_pc_i = 0;
    deact_valid_i = 0; deact_tid_i = 0;
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
    clr();
  endtask

  task automatic lane(input int l, input int t, input int s, input bit c,
                      input logic [PW-1:0] tg, input logic [PW-1:0] pc);
    sq_valid_i[l] = 1'b1;
    sq_tid_i[l*TW +: TW] = TW'(t);
    sq_seq_i[l*SW +: SW] = SW'(s);
    sq_is_ctrl_i[l] = c;
    sq_target_i[l*PW +: PW] = tg;
    sq_pc_i[l*PW +: PW] = pc;
  endtask

  task automatic bu(input int t, input int stg, input int s, input bit c,
                    input bit r, input bit tk, input logic [PW-1:0] tg);
    bu_valid_i = 1; bu_tid_i = TW'(t); bu_stage_i = GW'(stg); bu_seq_i = SW'(s);
    bu_is_ctrl_i = c; bu_is_ret_i = r; bu_pred_taken_i = tk; bu_target_i = tg;
  endtask

  task automatic fetch(input int t, input bit exp_gnt, input string tag);
    @(negedge clk_i);
    fetch_req_i = 1; fetch_tid_i = TW'(t);
    #2;
    chk(fetch_gnt_o == exp_gnt && fetch_stall_o == !exp_gnt, tag, 64'(fetch_gnt_o), 64'(exp_gnt));
    if (exp_gnt) begin
      chk(fetch_addr_o == m_pc[t], {tag, " addr"}, 64'(fetch_addr_o), 64'(m_pc[t]));
      chk(fetch_seq_o == m_seq[t], {tag, " seq"}, 64'(fetch_seq_o), 64'(m_seq[t]));
    end
    tick();
    if (exp_gnt) begin
      m_pc[t] = m_pc[t] + 4;
      m_seq[t] = m_seq[t] + 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    clr();
    for (int t = 0; t < NT; t++) begin m_pc[t] = 0; m_seq[t] = 0; end
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    // R12 reset state
    chk(block_o == 0 && unblock_o == 0 && sqo_valid_o == 0, "R12 pulses idle", 64'(block_o), 0);
    for (int t = 0; t < NT; t++) fetch(t, 0, "R12 R1 invalid after reset");

    // R9 activation
    for (int t = 0; t < NT; t++) begin
      @(negedge clk_i);
      act_valid_i = 1; act_tid_i = TW'(t); act_pc_i = PW'(32'h1000 * (t + 1));
      tick();
      m_pc[t] = PW'(32'h1000 * (t + 1));
    end
    // R2 interleaved sweep
    for (int r = 0; r < 6; r++)
      for (int t = 0; t < NT; t++) fetch((t + r) % NT, 1, "R2 R9 sweep");

    // R4 taken redirect
    @(negedge clk_i);
    bu(1, 2, 16'h33, 1, 0, 1, 32'h8000);
    tick();
    chk(sqo_valid_o && sqo_seq_o == 16'h33 && sqo_tid_o == 1 && sqo_stage_o == 2,
        "R4 squash out", {sqo_valid_o, 15'h0, sqo_seq_o}, {1'b1, 15'h0, 16'h33});
    m_pc[1] = 32'h8000;
    fetch(1, 1, "R4 target fetch");

    // R5 non-control and not-taken non-return
    @(negedge clk_i);
    bu(2, 1, 9, 0, 0, 1, 32'h9999);
    tick();
    chk(!sqo_valid_o, "R5 no squash non-ctrl", 64'(sqo_valid_o), 0);
    @(negedge clk_i);
    bu(2, 1, 9, 1, 0, 0, 32'h7777);
    tick();
    chk(!sqo_valid_o, "R5 no squash not-taken", 64'(sqo_valid_o), 0);
    fetch(2, 1, "R5 pc unchanged");

    // R3 park on return
    @(negedge clk_i);
    bu(3, 3, 4, 1, 1, 0, 32'h0);
    tick();
    chk(block_o == PLW'(1) << (3 * NT + 3), "R3 block bit", 64'(block_o), 64'(1) << 15);
    fetch(3, 0, "R3 R1 parked stall");

    // R6 R7 R8 oldest lane wins, unblock recorded stage
    @(negedge clk_i);
    lane(0, 3, 20, 1, 32'hA000, 32'h0);
    lane(1, 3, 10, 0, 32'h0, 32'hB000);
    tick();
    chk(unblock_o == PLW'(1) << (3 * NT + 3), "R8 unblock bit", 64'(unblock_o), 64'(1) << 15);
    m_pc[3] = 32'hB004;
    fetch(3, 1, "R6 R7 oldest lane pc+4");

    // R6 tie, R8 valid thread no unblock, different threads both apply
    @(negedge clk_i);
    lane(0, 0, 5, 1, 32'hC000, 32'h0);
    lane(1, 0, 5, 1, 32'hD000, 32'h0);
    tick();
    chk(unblock_o == 0, "R8 no unblock when valid", 64'(unblock_o), 0);
    m_pc[0] = 32'hC000;
    fetch(0, 1, "R6 tie lowest lane");
    @(negedge clk_i);
    lane(0, 1, 7, 0, 32'h0, 32'h100);
    lane(1, 2, 3, 1, 32'h200, 32'h0);
    tick();
    m_pc[1] = 32'h104; m_pc[2] = 32'h200;
    fetch(1, 1, "R6 R7 lane0 other thread");
    fetch(2, 1, "R6 R7 lane1 other thread");

    // R11 squash beats same-cycle fetch
    @(negedge clk_i);
    lane(0, 2, 1, 0, 32'h0, 32'h2000);
    fetch_req_i = 1; fetch_tid_i = 2;
    #2 chk(fetch_stall_o && !fetch_gnt_o, "R11 fetch stalled by squash", 64'(fetch_gnt_o), 0);
    tick();
    m_pc[2] = 32'h2004;
    fetch(2, 1, "R11 counter held");

    // R10 deactivate resets blocking stage
    @(negedge clk_i);
    bu(1, 4, 2, 1, 1, 0, 32'h0);
    tick();
    chk(block_o == PLW'(1) << (4 * NT + 1), "R3 block stage4", 64'(block_o), 64'(1) << 17);
    @(negedge clk_i);
    deact_valid_i = 1; deact_tid_i = 1;
    tick();
    fetch(1, 0, "R10 deactivated stall");
    @(negedge clk_i);
    lane(1, 1, 8, 0, 32'h0, 32'h3000);
    tick();
    chk(unblock_o == PLW'(1) << 1, "R10 R8 unblock stage0", 64'(unblock_o), 64'(2));
    m_pc[1] = 32'h3004;
    fetch(1, 1, "R10 revalidated");

    // R13 priorities
    @(negedge clk_i);
    act_valid_i = 1; act_tid_i = 0; act_pc_i = 32'hE000;
    lane(0, 0, 1, 1, 32'hF000, 32'h0);
    tick();
    m_pc[0] = 32'hE000;
    fetch(0, 1, "R13 activate over squash");
    @(negedge clk_i);
    deact_valid_i = 1; deact_tid_i = 2;
    act_valid_i = 1; act_tid_i = 2; act_pc_i = 32'h4444;
    tick();
    fetch(2, 0, "R13 deactivate over activate");
    @(negedge clk_i);
    lane(0, 3, 6, 1, 32'h5000, 32'h0);
    bu(3, 1, 16'h55, 1, 0, 1, 32'h6000);
    tick();
    chk(sqo_valid_o && sqo_seq_o == 16'h55, "R13 R4 squash out kept", 64'(sqo_seq_o), 64'h55);
    m_pc[3] = 32'h5000;
    fetch(3, 1, "R13 squash over branch update");

    // R1 sequence counter untouched across stalls
    @(negedge clk_i);
    act_valid_i = 1; act_tid_i = 2; act_pc_i = 32'h4444;
    tick();
    m_pc[2] = 32'h4444;
    fetch(2, 1, "R1 seq held across stalls");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule